// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a serial audio stream in which left and right samples share one data line. It rebuilds each pair into two parallel 32-bit words for a downstream filter path. A bit clock qualifies every data bit, and a frame clock tells which channel the bit belongs to. Four framings are supported: left-justified, I2S, right-justified and a DSP-style burst framing. Word lengths run from 16 to 32 bits.

All pins are sampled in the system clock domain through a short synchronizer. The rising edges of the bit clock are found there. In slave mode the bit clock and frame clock arrive on input pins. In master mode the block makes both clocks itself, drives them out and raises their output enables. The serial data pin is an input in both modes. Each completed left/right pair is announced by a one-cycle strobe. A frame that ends before a whole word has arrived sets a sticky underrun flag.

Top module: `pcm_serial_rx`

## Requirements
- R1: Serial data is assembled most significant bit first: the earliest captured bit of a word becomes its bit N-1, where N is the effective word length.
- R2: A data bit is taken only at a rising edge of the bit clock, and the pair strobe rises only in the cycle after such an edge has been detected.
- R3: With `mode`=0 (left-justified), a frame-clock high level marks the left channel. The MSB is the bit present at the first rising bit-clock edge after a frame-clock change.
- R4: With `mode`=1 (I2S), a frame-clock low level marks the left channel. The MSB is the bit present at the second rising edge after a frame-clock change.
- R5: With `mode`=2 (right-justified), a frame-clock high level marks the left channel. The word is the last N bits seen before the next frame-clock change, and earlier bits in the slot have no effect.
- R6: With `mode`=3 (DSP framing), a rising frame clock starts a frame. The left MSB is at the second rising edge after that rise, and the right MSB follows directly after the left LSB.
- R7: The effective length N is `word_len` limited to 16..32. In right-justified mode a value of 32 is reduced to 31.
- R8: With `align_left`=0 the word is right-aligned and sign-extended from bit N-1. With `align_left`=1 it sits in bits 31..32-N with zeros below.
- R9: `pair_valid_o` is a single-cycle pulse per completed left-then-right pair, and it updates `left_o` and `right_o`. A word that started before the first frame-clock change after reset is not delivered.
- R10: A word that closes with fewer than N bits sets `underrun_o`, which stays set until reset. The bits received fill the top of the word and the missing low bits are zero.
- R11: With `master`=1 the block drives `bclk_o` and `lrc_o` with their enables high. The bit clock period is 2*HALF_DIV system clocks. The frame clock changes only on bit-clock falling edges, and toggles every SLOT_BITS bits (a one-bit pulse per 2*SLOT_BITS bits in DSP framing). With `master`=0 both enables are low.
- R12: In left-justified and I2S modes, bits after the N-th bit of a slot have no effect on the delivered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master | input | 1 | 1: block generates bit and frame clocks |
| mode | input | 2 | Framing: 0 left-justified, 1 I2S, 2 right-justified, 3 DSP |
| word_len | input | 6 | Requested word length in bits |
| align_left | input | 1 | Output placement: 0 sign-extended, 1 left-aligned |
| bclk_i | input | 1 | Bit clock pin input (slave) |
| lrc_i | input | 1 | Frame clock pin input (slave) |
| sdata_i | input | 1 | Serial data pin, always an input |
| bclk_o | output | 1 | Generated bit clock (master) |
| bclk_oe | output | 1 | Output enable for the bit clock pin |
| lrc_o | output | 1 | Generated frame clock (master) |
| lrc_oe | output | 1 | Output enable for the frame clock pin |
| left_o | output | 32 | Last delivered left sample |
| right_o | output | 32 | Last delivered right sample |
| pair_valid_o | output | 1 | One-cycle strobe per delivered pair |
| underrun_o | output | 1 | Sticky short-frame flag |

## Verification
The bench builds the block with HALF_DIV=4 and SLOT_BITS=16. The generated bit clock then has an eight-cycle period, and a whole master frame of 32 bits fits into a few hundred cycles. This lets one run check the generated clock shape and a master-mode capture next to the slave tests. In slave mode the bench picks its own slot widths (16 to 32 bits per channel), so it can reach a slot shorter than the word, which causes an underrun. It also reaches full 32-bit words and the clamped right-justified 31-bit case.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int SAMPLE_W = 32;
  localparam int LEN_W    = 6;

  localparam logic [1:0] FMT_LJ  = 2'd0;
  localparam logic [1:0] FMT_I2S = 2'd1;
  localparam logic [1:0] FMT_RJ  = 2'd2;
  localparam logic [1:0] FMT_DSP = 2'd3;

  // Effective word length for a requested length and framing.
  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] req,
                                               input logic [1:0] fmt);
    logic [LEN_W-1:0] n;
    n = (req < 6'd16) ? 6'd16 : ((req > 6'd32) ? 6'd32 : req);
    if (fmt == FMT_RJ && n == 6'd32) n = 6'd31;
    return n;
  endfunction

  // Keep the newest min(k,n) bits and move them to the top of an n-bit word.
  function automatic logic [SAMPLE_W-1:0] close_word(input logic [SAMPLE_W-1:0] sh,
                                                     input logic [LEN_W-1:0] k,
                                                     input logic [LEN_W-1:0] n);
    logic [LEN_W-1:0] ke;
    logic [63:0] msk, w;
    ke  = (k < n) ? k : n;
    msk = (64'd1 << ke) - 64'd1;
    w   = ({32'd0, sh} & msk) << (n - ke);
    return w[SAMPLE_W-1:0];
  endfunction

  // Place an n-bit word in the output register.
  function automatic logic [SAMPLE_W-1:0] place(input logic [SAMPLE_W-1:0] w,
                                                input logic [LEN_W-1:0] n,
                                                input logic left);
    logic [63:0] t, lowmask;
    if (left) begin
      t = {32'd0, w} << (6'd32 - n);
    end else begin
      lowmask = (64'd1 << n) - 64'd1;
      t = {32'd0, w} & lowmask;
      if (w[n-1]) t = t | ~lowmask;
    end
    return t[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/pcm_rx_front.sv
module pcm_rx_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic lrc,
  input  logic sd,
  output logic bit_stb,
  output logic lrc_bit,
  output logic sd_bit
);
  localparam int NSIG = 3;

  logic [NSIG-1:0]   raw;
  logic [STAGES-1:0] chain [NSIG];
  logic              b_prev;

  assign raw = {bclk, lrc, sd};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) chain[g] <= '0;
      else        chain[g] <= {chain[g][STAGES-2:0], raw[g]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) b_prev <= 1'b0;
    else        b_prev <= chain[2][STAGES-1];
  end

  assign bit_stb = chain[2][STAGES-1] & ~b_prev;
  assign lrc_bit = chain[1][STAGES-1];
  assign sd_bit  = chain[0][STAGES-1];

  // R2: a rising edge is seen for exactly one cycle
  assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);
endmodule

// File: rtl/pcm_rx_clkgen.sv
module pcm_rx_clkgen
  import pcm_rx_pkg::*;
#(
  parameter int HALF_DIV  = 4,
  parameter int SLOT_BITS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] fmt,
  output logic       bclk,
  output logic       lrc
);
  localparam int FRAME = 2 * SLOT_BITS;
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME);

  logic [DIV_W-1:0] div;
  logic [BIT_W-1:0] bitc, nb;
  logic             half_done, left_lvl, idle_lvl, lrc_next;

  assign half_done = (div == DIV_W'(HALF_DIV - 1));
  assign left_lvl  = (fmt != FMT_I2S);
  assign idle_lvl  = (fmt == FMT_DSP) ? 1'b0 : ~left_lvl;
  assign nb        = (bitc == BIT_W'(FRAME - 1)) ? '0 : bitc + 1'b1;

  always_comb begin
    if (fmt == FMT_DSP) lrc_next = (nb == '0);
    else                lrc_next = (nb < BIT_W'(SLOT_BITS)) ? left_lvl : ~left_lvl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      div  <= '0;
      bclk <= 1'b0;
      bitc <= BIT_W'(FRAME - 1);
      lrc  <= idle_lvl;
    end else if (half_done) begin
      div  <= '0;
      bclk <= ~bclk;
      if (bclk) begin
        bitc <= nb;
        lrc  <= lrc_next;
      end
    end else begin
      div <= div + 1'b1;
    end
  end

  // R11: the generated frame clock moves only with a falling bit clock
  assert_lrc_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (en && $past(en) && !$stable(lrc)) |-> $fell(bclk));
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
  import pcm_rx_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int CW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt,
  input  logic [CW-1:0] n_len,
  input  logic          align_left,
  input  logic          bit_stb,
  input  logic          lrc_bit,
  input  logic          sd_bit,
  output logic [SW-1:0] left_o,
  output logic [SW-1:0] right_o,
  output logic          valid_o,
  output logic          underrun_o
);
  logic          primed, active, lrc_last, chan, have_left;
  logic [CW-1:0] k, k_inc;
  logic [SW-1:0] sh, sh_next, left_hold, closed_word, split_word;
  logic          is_dsp, left_lvl, new_chan, skip_first, cap_ok;
  logic          frame_edge, closing, close_short, dsp_split;

  assign is_dsp     = (fmt == FMT_DSP);
  assign left_lvl   = (fmt != FMT_I2S);
  assign skip_first = (fmt == FMT_I2S) || is_dsp;
  assign new_chan   = is_dsp ? 1'b0 : (lrc_bit != left_lvl);
  assign cap_ok     = (fmt == FMT_RJ) || (k < n_len);
  assign sh_next    = {sh[SW-2:0], sd_bit};
  assign k_inc      = (k == CW'(SW)) ? k : k + 1'b1;

  // Named events for the assertions and the update logic
  assign frame_edge  = primed && (is_dsp ? (lrc_bit && !lrc_last) : (lrc_bit != lrc_last));
  assign closing     = bit_stb && frame_edge && active;
  assign close_short = closing && (k < n_len);
  assign dsp_split   = bit_stb && !frame_edge && active && is_dsp && !chan && cap_ok
                       && (k_inc == n_len);
  assign closed_word = place(close_word(sh, k, n_len), n_len, align_left);
  assign split_word  = place(close_word(sh_next, n_len, n_len), n_len, align_left);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed <= 1'b0; active <= 1'b0; lrc_last <= 1'b0; chan <= 1'b0;
      have_left <= 1'b0; k <= '0; sh <= '0; left_hold <= '0;
      left_o <= '0; right_o <= '0; valid_o <= 1'b0; underrun_o <= 1'b0;
    end else begin
      valid_o    <= 1'b0;
      underrun_o <= underrun_o | close_short;
      if (bit_stb) begin
        primed   <= 1'b1;
        lrc_last <= lrc_bit;
        if (frame_edge) begin
          active <= 1'b1;
          chan   <= new_chan;
          if (active) begin
            if (!chan) begin
              if (is_dsp) begin
                left_o    <= closed_word;
                right_o   <= '0;
                valid_o   <= 1'b1;
                have_left <= 1'b0;
              end else begin
                left_hold <= closed_word;
                have_left <= 1'b1;
              end
            end else if (have_left) begin
              left_o    <= left_hold;
              right_o   <= closed_word;
              valid_o   <= 1'b1;
              have_left <= 1'b0;
            end
          end
          if (skip_first) begin
            sh <= '0;
            k  <= '0;
          end else begin
            sh <= {{(SW-1){1'b0}}, sd_bit};
            k  <= CW'(1);
          end
        end else if (active && cap_ok) begin
          if (dsp_split) begin
            left_hold <= split_word;
            have_left <= 1'b1;
            chan      <= 1'b1;
            sh        <= '0;
            k         <= '0;
          end else begin
            sh <= sh_next;
            k  <= k_inc;
          end
        end
      end
    end
  end

  // R9: one strobe per pair, never two in a row
  assert_pair_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R10: the short-frame flag never clears outside reset
  assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> underrun_o);
  // R10: the flag rises only right after a detected bit edge
  assert_underrun_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun_o) |-> $past(bit_stb));
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int SLOT_BITS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        master,
  input  logic [1:0]  mode,
  input  logic [5:0]  word_len,
  input  logic        align_left,
  input  logic        bclk_i,
  input  logic        lrc_i,
  input  logic        sdata_i,
  output logic        bclk_o,
  output logic        bclk_oe,
  output logic        lrc_o,
  output logic        lrc_oe,
  output logic [31:0] left_o,
  output logic [31:0] right_o,
  output logic        pair_valid_o,
  output logic        underrun_o
);
  logic             gen_bclk, gen_lrc, bclk_sel, lrc_sel;
  logic             bit_stb, lrc_bit, sd_bit;
  logic [LEN_W-1:0] n_eff;

  assign n_eff    = eff_len(word_len, mode);
  assign bclk_sel = master ? gen_bclk : bclk_i;
  assign lrc_sel  = master ? gen_lrc  : lrc_i;
  assign bclk_o   = gen_bclk;
  assign lrc_o    = gen_lrc;
  assign bclk_oe  = master;
  assign lrc_oe   = master;

  pcm_rx_clkgen #(.HALF_DIV(HALF_DIV), .SLOT_BITS(SLOT_BITS)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .en(master), .fmt(mode),
    .bclk(gen_bclk), .lrc(gen_lrc));

  pcm_rx_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .bclk(bclk_sel), .lrc(lrc_sel), .sd(sdata_i),
    .bit_stb(bit_stb), .lrc_bit(lrc_bit), .sd_bit(sd_bit));

  pcm_rx_deser #(.SW(SAMPLE_W), .CW(LEN_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .fmt(mode), .n_len(n_eff), .align_left(align_left),
    .bit_stb(bit_stb), .lrc_bit(lrc_bit), .sd_bit(sd_bit),
    .left_o(left_o), .right_o(right_o), .valid_o(pair_valid_o), .underrun_o(underrun_o));

  // R2: a delivered pair always follows a detected rising bit edge
  assert_pair_after_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_o |-> $past(bit_stb));
endmodule

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb;
  localparam int HALF = 4;
  localparam int SLOT = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, master = 1'b0, align_left = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [5:0]  word_len = 6'd16;
  logic        bclk_i = 1'b0, lrc_i = 1'b0, sdata_i = 1'b0;
  logic        bclk_o, bclk_oe, lrc_o, lrc_oe, pair_valid_o, underrun_o;
  logic [31:0] left_o, right_o;

  pcm_serial_rx #(.HALF_DIV(HALF), .SLOT_BITS(SLOT)) u_dut (
    .clk(clk), .rst_n(rst_n), .master(master), .mode(mode), .word_len(word_len),
    .align_left(align_left), .bclk_i(bclk_i), .lrc_i(lrc_i), .sdata_i(sdata_i),
    .bclk_o(bclk_o), .bclk_oe(bclk_oe), .lrc_o(lrc_o), .lrc_oe(lrc_oe),
    .left_o(left_o), .right_o(right_o), .pair_valid_o(pair_valid_o),
    .underrun_o(underrun_o));

  int          checks = 0, fails = 0;
  logic [31:0] exp_l[$], exp_r[$];
  string       cur_req = "R9";
  bit          done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Reference placement of an n-bit word
  function automatic logic [31:0] model_place(input logic [31:0] w, input int n, input bit al);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < n; b++) r[b] = w[b];
    if (al) begin
      r = r << (32 - n);
    end else begin
      for (int b = n; b < 32; b++) r[b] = w[n-1];
    end
    return r;
  endfunction

  // Per-clock comparison of delivered pairs against the model queue
  always @(negedge clk) begin
    if (rst_n && pair_valid_o) begin
      if (exp_l.size() == 0) begin
        chk("R9 unexpected pair", 32'd1, 32'd0);
      end else begin
        chk({cur_req, " left"},  left_o,  exp_l.pop_front());
        chk({cur_req, " right"}, right_o, exp_r.pop_front());
      end
    end
  end

  task automatic bit_out(input logic l, input logic d);
    @(posedge clk); #1;
    bclk_i = 1'b0; lrc_i = l; sdata_i = d;
    repeat (HALF) @(posedge clk);
    #1 bclk_i = 1'b1;
    repeat (HALF - 1) @(posedge clk);
  endtask

  task automatic do_reset(input logic m, input logic [1:0] md, input logic [5:0] wl, input logic al);
    @(posedge clk); #1;
    rst_n = 1'b0; master = m; mode = md; word_len = wl; align_left = al;
    bclk_i = 1'b0; lrc_i = 1'b0; sdata_i = 1'b0;
    exp_l.delete(); exp_r.delete();
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // Send one frame in slave mode; n is the effective length, slot the bits per channel
  task automatic send_frame(input logic [1:0] md, input int slot, input int n,
                            input logic [31:0] wl, input logic [31:0] wr);
    logic lvl_left, d;
    lvl_left = (md != 2'd1);
    if (md == 2'd3) begin
      for (int i = 0; i < 2 * slot; i++) begin
        d = 1'b1;
        if (i >= 1 && i <= n) d = wl[n - i];
        else if (i > n && i <= 2 * n) d = wr[2 * n - i];
        bit_out(i == 0, d);
      end
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        for (int i = 0; i < slot; i++) begin
          logic [31:0] w;
          w = (ch == 0) ? wl : wr;
          d = 1'b1;
          if (md == 2'd0 && i < n) d = w[n - 1 - i];
          if (md == 2'd1 && i >= 1 && i <= n) d = w[n - i];
          if (md == 2'd2 && i >= slot - n) d = w[slot - 1 - i];
          bit_out((ch == 0) ? lvl_left : ~lvl_left, d);
        end
      end
    end
  endtask

  // One slave test: reset, preamble, frames, flush, drain check
  task automatic run_slave(input string req, input logic [1:0] md, input logic [5:0] wl_req,
                           input int n, input bit al, input int slot, input int frames,
                           input logic [31:0] seed, input bit short_ok);
    logic [31:0] wl, wr, kl, kr;
    logic lvl_left;
    do_reset(1'b0, md, wl_req, al);
    cur_req = req;
    lvl_left = (md != 2'd1);
    bit_out((md == 2'd3) ? 1'b0 : ~lvl_left, 1'b0);
    for (int f = 0; f < frames; f++) begin
      wl = seed ^ (32'h9E3779B9 * (f + 1));
      wr = ~seed ^ (32'h7F4A7C15 * (f + 3));
      kl = wl; kr = wr;
      if (slot < n) begin
        for (int b = 0; b < n - slot; b++) begin kl[b] = 1'b0; kr[b] = 1'b0; end
      end
      exp_l.push_back(model_place(kl, n, al));
      exp_r.push_back(model_place(kr, n, al));
      send_frame(md, slot, n, wl, wr);
    end
    bit_out((md == 2'd3) ? 1'b1 : lvl_left, 1'b0);
    repeat (12) @(posedge clk);
    chk({req, " R9 all pairs delivered"}, exp_l.size(), 32'd0);
    chk({req, " R10 underrun flag"}, {31'd0, underrun_o}, {31'd0, short_ok});
  endtask

  // Master-mode drive: data follows generated bit clock falls
  logic [15:0] mwl [4];
  logic [15:0] mwr [4];
  bit          mfeed = 0;
  int          falls = 0, since_rise = 0, rises_lrc = 0, per_seen = 0, lrc_seen = 0;
  logic        pb = 1'b0, pl = 1'b0;

  always @(negedge clk) begin
    if (mfeed && rst_n) begin
      since_rise++;
      if (bclk_o && !pb) begin
        rises_lrc++;
        if (falls > 2 && per_seen < 3) begin
          chk("R11 bit clock period", since_rise, 2 * HALF);
          per_seen++;
        end
        since_rise = 0;
      end
      if (lrc_o != pl) begin
        if (falls > 2 && lrc_seen < 3) begin
          chk("R11 frame clock toggle spacing", rises_lrc, SLOT);
          lrc_seen++;
        end
        rises_lrc = 0;
      end
      if (!bclk_o && pb) begin
        int idx, fr, pos;
        falls++;
        idx = (falls - 1) % (2 * SLOT);
        fr  = (falls - 1) / (2 * SLOT);
        pos = idx % SLOT;
        if (fr < 4) sdata_i = (idx < SLOT) ? mwl[fr][15 - pos] : mwr[fr][15 - pos];
        else        sdata_i = 1'b0;
      end
      pb = bclk_o;
      pl = lrc_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    do_reset(1'b0, 2'd0, 6'd16, 1'b0);
    repeat (2) @(posedge clk);
    #1;
    chk("R9 reset valid", {31'd0, pair_valid_o}, 32'd0);
    chk("R10 reset underrun", {31'd0, underrun_o}, 32'd0);
    chk("R9 reset left", left_o, 32'd0);
    chk("R11 slave bclk_oe", {31'd0, bclk_oe}, 32'd0);
    chk("R11 slave lrc_oe", {31'd0, lrc_oe}, 32'd0);

    run_slave("R3 R1 R12 left-justified 16", 2'd0, 6'd16, 16, 1'b0, 32, 3, 32'h1234ABCD, 1'b0);
    run_slave("R4 R8 I2S 24 left-aligned",   2'd1, 6'd24, 24, 1'b1, 32, 3, 32'hC0FFEE11, 1'b0);
    run_slave("R5 right-justified 20",       2'd2, 6'd20, 20, 1'b0, 32, 3, 32'h5A5A0F0F, 1'b0);
    run_slave("R7 right-justified 32->31",   2'd2, 6'd32, 31, 1'b0, 32, 2, 32'hF00DBEEF, 1'b0);
    run_slave("R6 DSP framing 16",           2'd3, 6'd16, 16, 1'b0, 32, 3, 32'h8badf00d, 1'b0);
    run_slave("R1 R8 left-justified 32",     2'd0, 6'd32, 32, 1'b1, 32, 2, 32'h87654321, 1'b0);
    run_slave("R7 length 8 clamps to 16",    2'd0, 6'd8,  16, 1'b0, 24, 2, 32'h0000F00F, 1'b0);
    run_slave("R12 I2S 16 in 32-bit slot",   2'd1, 6'd16, 16, 1'b0, 32, 2, 32'h0BADCAFE, 1'b0);
    run_slave("R10 short slot zero pad",     2'd0, 6'd24, 24, 1'b0, 16, 2, 32'h00A5C3E7, 1'b1);

    // Master mode: left-justified, 16-bit words, generated clocks
    do_reset(1'b1, 2'd0, 6'd16, 1'b0);
    cur_req = "R11 master capture";
    for (int f = 0; f < 4; f++) begin
      mwl[f] = 16'h8001 ^ 16'(f * 16'h1357);
      mwr[f] = 16'h7FFE ^ 16'(f * 16'h2468);
      exp_l.push_back(model_place({16'd0, mwl[f]}, 16, 1'b0));
      exp_r.push_back(model_place({16'd0, mwr[f]}, 16, 1'b0));
    end
    falls = 0; since_rise = 0; rises_lrc = 0; per_seen = 0; lrc_seen = 0;
    pb = 1'b0; pl = lrc_o;
    mfeed = 1;
    #1;
    chk("R11 master bclk_oe", {31'd0, bclk_oe}, 32'd1);
    chk("R11 master lrc_oe", {31'd0, lrc_oe}, 32'd1);
    while (falls < 4 * 2 * SLOT + 1) @(posedge clk);
    repeat (4 * HALF + 10) @(posedge clk);
    mfeed = 0;
    chk("R11 master pairs delivered", exp_l.size(), 32'd0);
    chk("R10 master no underrun", {31'd0, underrun_o}, 32'd0);

    done = 1;
    report();
    $finish;
  end
endmodule